// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Words are 9 bits wide by default and the depth is a power-of-two parameter, 256 by default. Each side keeps its own binary pointer. Each pointer crosses to the other side as Gray code through a chain of synchronising flops. Every status flag is computed from the local pointer and the synchronised remote pointer, and is registered in the domain that owns it. A flag may therefore release late, but it never asserts late.

A single active-low reset clears both sides. While reset is held, the write side samples its dual-purpose control input to pick one of two operating modes:

- **Two-enable mode** (input high during reset): the input is a second, active-high write enable.
- **Programmable mode** (input low during reset): the input becomes a load strobe. While the strobe is low, writes and reads reach two threshold registers instead of the data array: the near-empty level and the near-full level.

Reads need both read enables low. The output word register changes only on a qualified read. An output-enable input blanks the output port to zero.

Top module: `pflag_dc_fifo`

## Requirements
- R1: While `rst_n` is low, `empty_n` and `aempty_n` are 0, `full_n` and `afull_n` are 1, and `rd_data` is 0 (with `out_en_n` low).
- R2: The level of `wr_en2_ld` during reset selects the mode. A 1 selects two-enable mode. A 0 selects programmable mode. In two-enable mode a low `wr_en2_ld` never alters the threshold registers.
- R3: A data word is stored on a rising `wr_clk` edge only when `wr_en1_n` is 0 and `wr_en2_ld` is 1. This holds in both modes.
- R4: No word is stored while `full_n` is 0, and no word is taken while `empty_n` is 0. Such attempts leave the contents, the order and `rd_data` unchanged.
- R5: A word is taken on a rising `rd_clk` edge only when `rd_en1_n` and `rd_en2_n` are both 0. The oldest stored word then appears on `rd_data` after that edge.
- R6: Once both clocks have idled for a few cycles, `empty_n` is 0 exactly when the occupancy is 0, and `full_n` is 0 exactly when the occupancy equals DEPTH.
- R7: `aempty_n` is 0 when the occupancy is at or below the near-empty level. `afull_n` is 0 when the occupancy is at or above DEPTH minus the near-full level. Both levels reset to 7.
- R8: In programmable mode with `wr_en2_ld` at 0, each `wr_en1_n`-low write edge loads `wr_data` into a threshold register. The target alternates: near-empty first, then near-full, then near-empty again. Each read edge with both read enables low returns a threshold, zero-extended, on `rd_data` in the same alternating order. Its selector also starts at near-empty after reset. Neither access touches the data array or the pointers.
- R9: `rd_data` holds its value between reads. `out_en_n` at 1 forces `rd_data` to 0 without losing the held word.
- R10: Under simultaneous write and read traffic on unrelated clocks, words come out complete and in write order. Each Gray pointer changes in at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides; mode is sampled while low |
| wr_data | input | DW | Word to store, or threshold value in load access |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_en2_ld | input | 1 | Second active-high write enable, or active-low load strobe in programmable mode |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| out_en_n | input | 1 | Active-low output qualifier; high forces `rd_data` to 0 |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | Low when empty, registered on `rd_clk` |
| aempty_n | output | 1 | Low when near empty, registered on `rd_clk` |
| full_n | output | 1 | Low when full, registered on `wr_clk` |
| afull_n | output | 1 | Low when near full, registered on `wr_clk` |

## Verification
A store and a take can land in the same interval: one edge of `wr_clk` and one of `rd_clk` close together, with each side seeing a stale copy of the other's pointer. The bench provokes this in two ways. It reads one word while the buffer is full. It also runs a long phase in which a writer and a reader operate concurrently on clocks of 20 ns and 29 ns periods, so the edges drift through every phase relation. The result is judged by the scoreboard queue, which requires every word to emerge exactly once and in order, and by the four flags settling to the right values once traffic stops.

// File: rtl/pflag_dc_fifo_pkg.sv
`timescale 1ns/1ps
package pflag_dc_fifo_pkg;

   // operating mode latched while reset is asserted
   typedef enum logic {
      MODE_TWO_WEN = 1'b0,
      MODE_PROG    = 1'b1
   } wr_mode_e;

   // which threshold register the next load/readback targets
   typedef enum logic {
      SEL_NEAR_EMPTY = 1'b0,
      SEL_NEAR_FULL  = 1'b1
   } lvl_sel_e;

   function automatic lvl_sel_e next_sel(input lvl_sel_e cur);
      return (cur == SEL_NEAR_EMPTY) ? SEL_NEAR_FULL : SEL_NEAR_EMPTY;
   endfunction

endpackage

// File: rtl/pflag_dc_fifo_ram.sv
`timescale 1ns/1ps
module pflag_dc_fifo_ram #(
   parameter int DW    = 9,
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/pflag_dc_fifo_xing.sv
`timescale 1ns/1ps
module pflag_dc_fifo_xing #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] q;
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= gray_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   logic [W-1:0] gray_sync;
   assign gray_sync = g_stage[STAGES-1].q;

   // each binary bit is the parity of the gray bits at and above it
   always_comb begin
      for (int i = 0; i < W; i++) begin
         bin_out[i] = ^(gray_sync >> i);
      end
   end

endmodule

// File: rtl/pflag_dc_fifo_wr.sv
`timescale 1ns/1ps
module pflag_dc_fifo_wr
   import pflag_dc_fifo_pkg::*;
#(
   parameter int DW        = 9,
   parameter int DEPTH     = 256,
   parameter int AW        = 8,
   parameter int NE_LVL_RST = 7,
   parameter int NF_LVL_RST = 7
) (
   input  logic          wr_clk,
   input  logic          rst_n,
   input  logic          wen1_n,
   input  logic          wen2_ld,
   input  logic [DW-1:0] wdata,
   input  logic [AW:0]   rptr_sync,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [AW:0]   wptr_bin,
   output logic [AW:0]   wptr_gray,
   output logic          full_n,
   output logic          afull_n,
   output logic [AW-1:0] lvl_near_empty,
   output logic [AW-1:0] lvl_near_full
);

   localparam int CW = AW + 1;
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   wr_mode_e      mode_q;
   lvl_sel_e      sel_q;
   logic [CW-1:0] wptr_q, wptr_nxt, fill_nxt, nf_mark;
   logic [AW-1:0] ne_q, nf_q, lvl_in;
   logic          data_we, lvl_we, full_n_q, afull_n_q;

   // mode capture: synchronous sample while reset is held
   always_ff @(posedge wr_clk) begin
      if (!rst_n) mode_q <= wen2_ld ? MODE_TWO_WEN : MODE_PROG;
   end

   assign lvl_in   = AW'(wdata);
   assign lvl_we   = (mode_q == MODE_PROG) && !wen1_n && !wen2_ld;
   assign data_we  = !wen1_n && wen2_ld && full_n_q;
   assign wptr_nxt = wptr_q + CW'(data_we);
   assign fill_nxt = wptr_nxt - rptr_sync;
   assign nf_mark  = DEPTH_C - {1'b0, nf_q};

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q    <= '0;
         wptr_gray <= '0;
         full_n_q  <= 1'b1;
         afull_n_q <= 1'b1;
      end else begin
         wptr_q    <= wptr_nxt;
         wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
         full_n_q  <= (fill_nxt != DEPTH_C);
         afull_n_q <= (fill_nxt < nf_mark);
      end
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ne_q  <= AW'(NE_LVL_RST);
         nf_q  <= AW'(NF_LVL_RST);
         sel_q <= SEL_NEAR_EMPTY;
      end else if (lvl_we) begin
         if (sel_q == SEL_NEAR_EMPTY) ne_q <= lvl_in;
         else                         nf_q <= lvl_in;
         sel_q <= next_sel(sel_q);
      end
   end

   assign mem_we         = data_we;
   assign mem_addr       = wptr_q[AW-1:0];
   assign wptr_bin       = wptr_q;
   assign full_n         = full_n_q;
   assign afull_n        = afull_n_q;
   assign lvl_near_empty = ne_q;
   assign lvl_near_full  = nf_q;

endmodule

// File: rtl/pflag_dc_fifo_rd.sv
`timescale 1ns/1ps
module pflag_dc_fifo_rd
   import pflag_dc_fifo_pkg::*;
#(
   parameter int DW    = 9,
   parameter int DEPTH = 256,
   parameter int AW    = 8
) (
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          ren1_n,
   input  logic          ren2_n,
   input  logic          ld_pin,
   input  logic [AW:0]   wptr_sync,
   input  logic [DW-1:0] mem_rdata,
   input  logic [AW-1:0] lvl_near_empty,
   input  logic [AW-1:0] lvl_near_full,
   output logic [AW-1:0] mem_addr,
   output logic [AW:0]   rptr_bin,
   output logic [AW:0]   rptr_gray,
   output logic          empty_n,
   output logic          aempty_n,
   output logic [DW-1:0] word_q
);

   localparam int CW = AW + 1;

   wr_mode_e      mode_q;
   lvl_sel_e      sel_q;
   logic [CW-1:0] rptr_q, rptr_nxt, fill_nxt;
   logic          ren, lvl_acc, data_re, lvl_re, empty_n_q, aempty_n_q;
   logic [DW-1:0] lvl_word;

   // the read side latches the same mode from the same pin
   always_ff @(posedge rd_clk) begin
      if (!rst_n) mode_q <= ld_pin ? MODE_TWO_WEN : MODE_PROG;
   end

   assign ren      = !ren1_n && !ren2_n;
   assign lvl_acc  = (mode_q == MODE_PROG) && !ld_pin;
   assign data_re  = ren && !lvl_acc && empty_n_q;
   assign lvl_re   = ren && lvl_acc;
   assign rptr_nxt = rptr_q + CW'(data_re);
   assign fill_nxt = wptr_sync - rptr_nxt;
   assign lvl_word = (sel_q == SEL_NEAR_EMPTY) ? DW'(lvl_near_empty) : DW'(lvl_near_full);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q     <= '0;
         rptr_gray  <= '0;
         empty_n_q  <= 1'b0;
         aempty_n_q <= 1'b0;
      end else begin
         rptr_q     <= rptr_nxt;
         rptr_gray  <= rptr_nxt ^ (rptr_nxt >> 1);
         empty_n_q  <= (fill_nxt != '0);
         aempty_n_q <= (fill_nxt > {1'b0, lvl_near_empty});
      end
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         sel_q  <= SEL_NEAR_EMPTY;
      end else if (data_re) begin
         word_q <= mem_rdata;
      end else if (lvl_re) begin
         word_q <= lvl_word;
         sel_q  <= next_sel(sel_q);
      end
   end

   assign mem_addr = rptr_q[AW-1:0];
   assign rptr_bin = rptr_q;
   assign empty_n  = empty_n_q;
   assign aempty_n = aempty_n_q;

endmodule

// File: rtl/pflag_dc_fifo.sv
`timescale 1ns/1ps
module pflag_dc_fifo #(
   parameter int DW          = 9,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter int NE_LVL_RST  = 7,
   parameter int NF_LVL_RST  = 7
) (
   input  logic          wr_clk,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic [DW-1:0] wr_data,
   input  logic          wr_en1_n,
   input  logic          wr_en2_ld,
   input  logic          rd_en1_n,
   input  logic          rd_en2_n,
   input  logic          out_en_n,
   output logic [DW-1:0] rd_data,
   output logic          empty_n,
   output logic          aempty_n,
   output logic          full_n,
   output logic          afull_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("DW must be at least 1");
   end
   if (NE_LVL_RST < 0 || NE_LVL_RST >= DEPTH ||
       NF_LVL_RST < 0 || NF_LVL_RST >= DEPTH) begin : g_bad_lvl
      $error("threshold reset values must lie in 0..DEPTH-1");
   end

   logic          mem_we;
   logic [AW-1:0] mem_waddr, mem_raddr;
   logic [DW-1:0] mem_rdata, rd_q;
   logic [CW-1:0] wptr_bin, wgray, rptr_bin, rgray, wq_bin, rq_bin;
   logic [AW-1:0] lvl_ne, lvl_nf;

   pflag_dc_fifo_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
      .wr_clk (wr_clk),
      .we     (mem_we),
      .waddr  (mem_waddr),
      .wdata  (wr_data),
      .raddr  (mem_raddr),
      .rdata  (mem_rdata)
   );

   pflag_dc_fifo_wr #(
      .DW(DW), .DEPTH(DEPTH), .AW(AW),
      .NE_LVL_RST(NE_LVL_RST), .NF_LVL_RST(NF_LVL_RST)
   ) u_wr (
      .wr_clk         (wr_clk),
      .rst_n          (rst_n),
      .wen1_n         (wr_en1_n),
      .wen2_ld        (wr_en2_ld),
      .wdata          (wr_data),
      .rptr_sync      (rq_bin),
      .mem_we         (mem_we),
      .mem_addr       (mem_waddr),
      .wptr_bin       (wptr_bin),
      .wptr_gray      (wgray),
      .full_n         (full_n),
      .afull_n        (afull_n),
      .lvl_near_empty (lvl_ne),
      .lvl_near_full  (lvl_nf)
   );

   pflag_dc_fifo_rd #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_rd (
      .rd_clk         (rd_clk),
      .rst_n          (rst_n),
      .ren1_n         (rd_en1_n),
      .ren2_n         (rd_en2_n),
      .ld_pin         (wr_en2_ld),
      .wptr_sync      (wq_bin),
      .mem_rdata      (mem_rdata),
      .lvl_near_empty (lvl_ne),
      .lvl_near_full  (lvl_nf),
      .mem_addr       (mem_raddr),
      .rptr_bin       (rptr_bin),
      .rptr_gray      (rgray),
      .empty_n        (empty_n),
      .aempty_n       (aempty_n),
      .word_q         (rd_q)
   );

   pflag_dc_fifo_xing #(.W(CW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .gray_in (wgray),
      .bin_out (wq_bin)
   );

   pflag_dc_fifo_xing #(.W(CW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .gray_in (rgray),
      .bin_out (rq_bin)
   );

   assign rd_data = out_en_n ? '0 : rd_q;

endmodule

// File: rtl/pflag_dc_fifo_chk.sv
`timescale 1ns/1ps
module pflag_dc_fifo_chk #(
   parameter int CW = 9,
   parameter int DW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          wr_en1_n,
   input logic          wr_en2_ld,
   input logic          rd_en1_n,
   input logic          rd_en2_n,
   input logic          full_n,
   input logic          afull_n,
   input logic          empty_n,
   input logic          aempty_n,
   input logic [CW-1:0] wptr_bin,
   input logic [CW-1:0] rptr_bin,
   input logic [CW-1:0] wgray,
   input logic [CW-1:0] rgray,
   input logic [DW-1:0] rd_q
);

   AST_WR_QUALIFIED: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_en1_n || !wr_en2_ld) |=> (wptr_bin == $past(wptr_bin))); // R3

   AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |=> (wptr_bin == $past(wptr_bin))); // R4

   AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> (rptr_bin == $past(rptr_bin))); // R4

   AST_RD_QUALIFIED: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en1_n || rd_en2_n) |=> (rptr_bin == $past(rptr_bin))); // R5

   AST_WORD_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (rd_en1_n || rd_en2_n) |=> $stable(rd_q)); // R9

   AST_EMPTY_IMPLIES_NEAR: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n); // R7

   AST_FULL_IMPLIES_NEAR: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !full_n |-> !afull_n); // R7

   AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $countones(wgray ^ $past(wgray)) <= 1); // R10

   AST_RGRAY_ONE_BIT: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $countones(rgray ^ $past(rgray)) <= 1); // R10

endmodule

bind pflag_dc_fifo pflag_dc_fifo_chk #(.CW(CW), .DW(DW)) u_chk (
   .wr_clk    (wr_clk),
   .rd_clk    (rd_clk),
   .rst_n     (rst_n),
   .wr_en1_n  (wr_en1_n),
   .wr_en2_ld (wr_en2_ld),
   .rd_en1_n  (rd_en1_n),
   .rd_en2_n  (rd_en2_n),
   .full_n    (full_n),
   .afull_n   (afull_n),
   .empty_n   (empty_n),
   .aempty_n  (aempty_n),
   .wptr_bin  (wptr_bin),
   .rptr_bin  (rptr_bin),
   .wgray     (wgray),
   .rgray     (rgray),
   .rd_q      (rd_q)
);

// File: tb/pflag_dc_fifo_test.sv
`timescale 1ns/1ps
module pflag_dc_fifo_test;

   localparam int DEPTH = 256;

   logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b1;
   logic [8:0] wr_data = '0;
   logic       wr_en1_n = 1'b1, wr_en2_ld = 1'b1;
   logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
   logic [8:0] rd_data;
   logic       empty_n, aempty_n, full_n, afull_n;

   int         n_chk = 0, n_bad = 0;
   bit         prog_tb = 1'b0, rd_fire = 1'b0, wr_done = 1'b0, ended = 1'b0;
   logic [8:0] sb[$];
   logic [8:0] wval = 9'd1, last_pop = '0;

   pflag_dc_fifo uut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_data(wr_data), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
      .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
      .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n),
      .full_n(full_n), .afull_n(afull_n)
   );

   always #10   wr_clk = ~wr_clk;   // 50 MHz
   always #14.5 rd_clk = ~rd_clk;   // unrelated read clock

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: a data take at this edge is decided from pre-edge port values
   always @(posedge rd_clk)
      rd_fire <= !rd_en1_n && !rd_en2_n && empty_n && rst_n && !(prog_tb && !wr_en2_ld);

   always @(negedge rd_clk) begin
      if (rd_fire) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R4", "take with empty scoreboard", 1, 0);
         end else begin
            last_pop = sb.pop_front();
            chk(rd_data == last_pop, "R5", "word order", rd_data, last_pop);
         end
      end
   end

   task automatic settle();
      repeat (6) @(posedge wr_clk);
      repeat (6) @(posedge rd_clk);
      @(negedge rd_clk);
   endtask

   task automatic do_reset(input logic ld_level);
      rst_n = 1'b0; wr_en2_ld = ld_level; wr_en1_n = 1'b1;
      rd_en1_n = 1'b1; rd_en2_n = 1'b1; out_en_n = 1'b0;
      repeat (4) @(posedge wr_clk);
      repeat (4) @(posedge rd_clk);
      @(negedge rd_clk);
      chk(empty_n == 1'b0,  "R1", "empty_n in reset",  empty_n,  0);
      chk(aempty_n == 1'b0, "R1", "aempty_n in reset", aempty_n, 0);
      chk(full_n == 1'b1,   "R1", "full_n in reset",   full_n,   1);
      chk(afull_n == 1'b1,  "R1", "afull_n in reset",  afull_n,  1);
      chk(rd_data == '0,    "R1", "rd_data in reset",  rd_data,  0);
      @(negedge wr_clk);
      rst_n = 1'b1; wr_en2_ld = 1'b1;
      sb.delete(); last_pop = '0;
      prog_tb = !ld_level;
      settle();
   endtask

   // driver: one write edge; the word is expected only if accepted
   task automatic put_word(input logic [8:0] w, input logic e2);
      bit acc;
      @(negedge wr_clk);
      wr_data = w; wr_en1_n = 1'b0; wr_en2_ld = e2;
      acc = e2 && full_n;
      @(negedge wr_clk);
      wr_en1_n = 1'b1; wr_en2_ld = 1'b1;
      if (acc) sb.push_back(w);
   endtask

   task automatic fill_to(input int lvl);
      while (sb.size() < lvl) begin
         put_word(wval, 1'b1);
         wval = wval + 9'd37;
      end
   endtask

   task automatic rd_pulse(input logic e1, input logic e2);
      @(negedge rd_clk);
      rd_en1_n = e1; rd_en2_n = e2;
      @(negedge rd_clk);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
   endtask

   task automatic drain();
      @(negedge rd_clk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      wait (wr_done && sb.size() == 0);
      @(negedge rd_clk);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
   endtask

   task automatic check_level(input int eo, input int fo);
      int occ;
      settle();
      occ = sb.size();
      chk(empty_n == (occ != 0),         "R6", $sformatf("empty_n at %0d", occ), empty_n, occ != 0);
      chk(full_n == (occ != DEPTH),      "R6", $sformatf("full_n at %0d", occ), full_n, occ != DEPTH);
      chk(aempty_n == (occ > eo),        "R7", $sformatf("aempty_n at %0d", occ), aempty_n, occ > eo);
      chk(afull_n == (occ < DEPTH - fo), "R7", $sformatf("afull_n at %0d", occ), afull_n, occ < DEPTH - fo);
   endtask

   task automatic lvl_write(input logic [8:0] v);
      @(negedge wr_clk);
      wr_data = v; wr_en1_n = 1'b0; wr_en2_ld = 1'b0;
      @(negedge wr_clk);
      wr_en1_n = 1'b1;
   endtask

   task automatic lvl_read(input int exp);
      @(negedge rd_clk);
      rd_en1_n = 1'b0; rd_en2_n = 1'b0;
      @(negedge rd_clk);
      rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      chk(rd_data == 9'(exp), "R8", "threshold readback", rd_data, exp);
   endtask

   initial begin
      #3_000_000;
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [8:0] held;
      #3;
      // ---------------- two-enable mode ----------------
      wr_done = 1'b1;
      do_reset(1'b1);
      fill_to(1);   check_level(7, 7);
      fill_to(7);   check_level(7, 7);
      put_word(9'h155, 1'b0);                    // second enable low: ignored
      settle();
      chk(aempty_n == 1'b0, "R3", "write with wr_en2_ld low stored", aempty_n, 0);
      fill_to(8);   check_level(7, 7);
      chk(aempty_n == 1'b1, "R2", "near-empty level kept at 7", aempty_n, 1);
      rd_pulse(1'b0, 1'b1);
      rd_pulse(1'b1, 1'b0);
      settle();
      chk(aempty_n == 1'b1, "R5", "single read enable took a word", aempty_n, 1);
      chk(rd_data == '0,    "R5", "rd_data after single enable", rd_data, 0);
      fill_to(248); check_level(7, 7);
      fill_to(249); check_level(7, 7);
      fill_to(255); check_level(7, 7);
      fill_to(256); check_level(7, 7);
      put_word(9'h0AA, 1'b1);                    // at full: dropped
      settle();
      chk(sb.size() == DEPTH, "R4", "scoreboard depth after write at full", sb.size(), DEPTH);
      chk(full_n == 1'b0,     "R4", "full_n after write at full", full_n, 0);
      rd_pulse(1'b0, 1'b0);                      // take while full
      check_level(7, 7);
      held = rd_data;
      settle();
      chk(rd_data == held, "R9", "rd_data held between reads", rd_data, held);
      out_en_n = 1'b1; #1;
      chk(rd_data == '0, "R9", "rd_data blanked by out_en_n", rd_data, 0);
      out_en_n = 1'b0; #1;
      chk(rd_data == held, "R9", "held word after re-enable", rd_data, held);
      drain();
      check_level(7, 7);
      rd_pulse(1'b0, 1'b0);
      rd_pulse(1'b0, 1'b0);
      settle();
      chk(rd_data == last_pop, "R4", "rd_data after take while empty", rd_data, last_pop);
      chk(empty_n == 1'b0,     "R4", "empty_n after take while empty", empty_n, 0);

      // ---------------- programmable mode ----------------
      do_reset(1'b0);
      lvl_write(9'd20);
      lvl_write(9'd30);
      settle();
      chk(empty_n == 1'b0, "R8", "threshold load stored a data word", empty_n, 0);
      lvl_read(20);
      lvl_read(30);
      lvl_read(20);
      @(negedge wr_clk); wr_en2_ld = 1'b1;
      settle();
      chk(empty_n == 1'b0, "R8", "threshold read moved pointers", empty_n, 0);
      fill_to(20);  check_level(20, 30);
      chk(aempty_n == 1'b0, "R2", "programmable level active", aempty_n, 0);
      fill_to(21);  check_level(20, 30);
      fill_to(225); check_level(20, 30);
      fill_to(226); check_level(20, 30);
      drain();
      check_level(20, 30);

      // concurrent traffic on both clocks
      wr_done = 1'b0;
      fork
         begin
            for (int i = 0; i < 120; i++) begin
               put_word(wval, 1'b1);
               wval = wval + 9'd11;
            end
            wr_done = 1'b1;
         end
         drain();
      join
      chk(sb.size() == 0, "R10", "words left after concurrent phase", sb.size(), 0);
      check_level(20, 30);
      finish_run();
   end

endmodule